// File: doc/BRIEF.md
# PDM Multichannel Bit Sampler

This block captures one-bit pulse-density audio from up to four microphone data lines. Each line carries two interleaved microphones, one per half period of the slow PDM bit clock, so the block serves eight channels. The PDM clock is not sampled on its own edges. A fast system clock runs through the PDM clock through a two-flop synchronizer and restarts a counter on every PDM transition. That counter measures how many system-clock cycles have passed in the current half period. Each channel takes its bit when the counter equals that channel's programmed pointer. This lets software place the capture point late in the half period, where the microphone output has settled. A typical value is three quarters of the half-period length.

Channel pointers arrive as two 32-bit words holding one byte per channel. An active-low per-channel reset mask and a per-channel enable mask select which channels run. A global enable gates the whole sampler. Each captured bit appears on its own output with a one-cycle valid strobe.

Top module: `pdm_bit_sampler`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, all `smp_bits` and `smp_valid` are 0.
- R2: A PDM clock level first seen at the clock edge t restarts the half-period count. A channel with pointer P then raises its valid for exactly the cycle after edge t+3+P. The bit it carries is its data line as sampled at edge t+1+P.
- R3: Channel 2k reads data line k only in the half period in which the PDM clock is high. Channel 2k+1 reads line k only in the half period in which it is low. A pointer that the half period never reaches gives no capture.
- R4: The pointer for channel c (c = 0..3) is `ptr_lo[8c+7:8c]`. The pointer for channel c (c = 4..7) is `ptr_hi[8(c-4)+7:8(c-4)]`.
- R5: While `chan_rstn[c]` is 0, channel c drives `smp_bits[c]` = 0 and never raises `smp_valid[c]`.
- R6: While `chan_rstn[c]` is 1 and `chan_en[c]` is 0, channel c raises no valid, and `smp_bits[c]` keeps its last captured value.
- R7: While `blk_en` is 0, the count is held at 0 and no valid is raised. After `blk_en` rises, no channel captures until the first PDM clock transition is detected.
- R8: The count stops at 255 when the PDM clock stalls. A channel whose pointer is 255 captures exactly once in that half period, and never again until the next PDM transition.
- R9: A valid strobe lasts one cycle. A channel raises at most one valid per half period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_en | input | 1 | Global sampler enable |
| pdm_clk_in | input | 1 | PDM bit clock (asynchronous to clk) |
| pdm_data | input | 4 | PDM data lines, two channels per line |
| ptr_lo | input | 32 | Sample pointers of channels 0..3, one byte each |
| ptr_hi | input | 32 | Sample pointers of channels 4..7, one byte each |
| chan_rstn | input | 8 | Per-channel active-low reset |
| chan_en | input | 8 | Per-channel enable |
| smp_bits | output | 8 | Last captured bit per channel |
| smp_valid | output | 8 | One-cycle capture strobe per channel |

## Verification
The hardest cases to reach from the ports are the counter saturation and the re-enable case. For saturation, the PDM clock must stay stalled for more than 256 system cycles while a channel of the matching parity holds pointer 255. The bench stops its PDM clock generator after forcing the clock high and keeps it there for 600 cycles. It then counts that channel's strobes. The re-enable case needs `blk_en` to rise while the PDM clock is frozen. The bench holds the clock steady across the enable and confirms that no channel fires before a transition arrives. A behavioural model driven by the same inputs predicts every output on every cycle, across sweeps of pointer values, half-period lengths and channel masks.

// File: rtl/pdm_smp_pkg.sv
package pdm_smp_pkg;
    localparam int CH_NUM     = 8;
    localparam int PTR_W      = 8;
    localparam int SLOTS      = 2;
    localparam int LINE_NUM   = CH_NUM / SLOTS;
    localparam int CH_PER_REG = 4;
    localparam int REG_W      = CH_PER_REG * PTR_W;
    localparam logic [PTR_W-1:0] PTR_MAX = '1;

    typedef struct packed {
        logic [PTR_W-1:0] cnt;
        logic             fresh;
        logic             level;
    } half_pos_t;

    function automatic logic slot_level(input int ch);
        return ((ch % SLOTS) == 0);
    endfunction

    function automatic int line_of(input int ch);
        return ch / SLOTS;
    endfunction
endpackage

// File: rtl/pdm_edge_sync.sv
module pdm_edge_sync
    import pdm_smp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                pdm_clk_in,
    input  logic [LINE_NUM-1:0] pdm_data,
    output logic                clk_edge,
    output logic                clk_lvl,
    output logic [LINE_NUM-1:0] dat_sync
);
    logic                clk_s1, clk_s2, clk_s3;
    logic [LINE_NUM-1:0] dat_s1, dat_s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_s1 <= 1'b0;
            clk_s2 <= 1'b0;
            clk_s3 <= 1'b0;
            dat_s1 <= '0;
            dat_s2 <= '0;
        end else begin
            clk_s1 <= pdm_clk_in;
            clk_s2 <= clk_s1;
            clk_s3 <= clk_s2;
            dat_s1 <= pdm_data;
            dat_s2 <= dat_s1;
        end
    end

    assign clk_edge = clk_s2 ^ clk_s3;
    assign clk_lvl  = clk_s2;
    assign dat_sync = dat_s2;
endmodule

// File: rtl/pdm_half_counter.sv
module pdm_half_counter
    import pdm_smp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      blk_en,
    input  logic      clk_edge,
    input  logic      clk_lvl,
    output half_pos_t pos
);
    logic locked;

    always_ff @(posedge clk) begin
        if (rst || !blk_en) begin
            pos    <= '0;
            locked <= 1'b0;
        end else if (clk_edge) begin
            pos.cnt   <= '0;
            pos.fresh <= 1'b1;
            pos.level <= clk_lvl;
            locked    <= 1'b1;
        end else if (locked && pos.cnt != PTR_MAX) begin
            pos.cnt   <= pos.cnt + 1'b1;
            pos.fresh <= 1'b1;
        end else begin
            pos.fresh <= 1'b0;
        end
    end

    p_off_clears_r7: assert property (@(posedge clk) disable iff (rst)
        !blk_en |=> (pos.cnt == '0) && !pos.fresh);

    p_edge_restart_r2: assert property (@(posedge clk) disable iff (rst)
        (blk_en && clk_edge) |=> (pos.cnt == '0) && pos.fresh);

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        (blk_en && !clk_edge && pos.cnt == PTR_MAX) |=> (pos.cnt == PTR_MAX) && !pos.fresh);
endmodule

// File: rtl/pdm_slot_capture.sv
module pdm_slot_capture
    import pdm_smp_pkg::*;
#(
    parameter int CH_IDX = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             blk_en,
    input  logic             ch_rstn,
    input  logic             ch_en,
    input  logic [PTR_W-1:0] ptr,
    input  half_pos_t        pos,
    input  logic             dat,
    output logic             smp_bit,
    output logic             smp_vld
);
    localparam logic WANT_LVL = slot_level(CH_IDX);

    logic hit;
    assign hit = blk_en && ch_en && pos.fresh && (pos.cnt == ptr) && (pos.level == WANT_LVL);

    always_ff @(posedge clk) begin
        if (rst || !ch_rstn) begin
            smp_bit <= 1'b0;
            smp_vld <= 1'b0;
        end else begin
            smp_vld <= hit;
            if (hit) smp_bit <= dat;
        end
    end

    p_rst_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !ch_rstn |=> !smp_vld && !smp_bit);

    p_slot_parity_r3: assert property (@(posedge clk) disable iff (rst)
        smp_vld |-> ($past(pos.level) == WANT_LVL));

    p_hold_when_off_r6: assert property (@(posedge clk) disable iff (rst)
        (ch_rstn && !ch_en) |=> !smp_vld && (smp_bit == $past(smp_bit)));
endmodule

// File: rtl/pdm_bit_sampler.sv
module pdm_bit_sampler
    import pdm_smp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                blk_en,
    input  logic                pdm_clk_in,
    input  logic [LINE_NUM-1:0] pdm_data,
    input  logic [REG_W-1:0]    ptr_lo,
    input  logic [REG_W-1:0]    ptr_hi,
    input  logic [CH_NUM-1:0]   chan_rstn,
    input  logic [CH_NUM-1:0]   chan_en,
    output logic [CH_NUM-1:0]   smp_bits,
    output logic [CH_NUM-1:0]   smp_valid
);
    logic                clk_edge, clk_lvl;
    logic [LINE_NUM-1:0] dat_sync;
    half_pos_t           pos;

    pdm_edge_sync u_sync (
        .clk(clk), .rst(rst), .pdm_clk_in(pdm_clk_in), .pdm_data(pdm_data),
        .clk_edge(clk_edge), .clk_lvl(clk_lvl), .dat_sync(dat_sync)
    );

    pdm_half_counter u_cnt (
        .clk(clk), .rst(rst), .blk_en(blk_en),
        .clk_edge(clk_edge), .clk_lvl(clk_lvl), .pos(pos)
    );

    for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
        logic [PTR_W-1:0] ch_ptr;
        if (c < CH_PER_REG) begin : g_lo
            assign ch_ptr = ptr_lo[c*PTR_W +: PTR_W];
        end else begin : g_hi
            assign ch_ptr = ptr_hi[(c-CH_PER_REG)*PTR_W +: PTR_W];
        end

        pdm_slot_capture #(.CH_IDX(c)) u_cap (
            .clk(clk), .rst(rst), .blk_en(blk_en),
            .ch_rstn(chan_rstn[c]), .ch_en(chan_en[c]), .ptr(ch_ptr),
            .pos(pos), .dat(dat_sync[line_of(c)]),
            .smp_bit(smp_bits[c]), .smp_vld(smp_valid[c])
        );
    end

    p_valid_needs_en_r7: assert property (@(posedge clk) disable iff (rst)
        (smp_valid != '0) |-> $past(blk_en));
endmodule

// File: tb/pdm_bit_sampler_tb_top.sv
module pdm_bit_sampler_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        blk_en = 1'b0;
    logic        pdm_clk_in = 1'b0;
    logic [3:0]  pdm_data = '0;
    logic [31:0] ptr_lo = '0;
    logic [31:0] ptr_hi = '0;
    logic [7:0]  chan_rstn = '0;
    logic [7:0]  chan_en = '0;
    logic [7:0]  smp_bits, smp_valid;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pdm_bit_sampler dut_i (
        .clk(clk), .rst(rst), .blk_en(blk_en), .pdm_clk_in(pdm_clk_in),
        .pdm_data(pdm_data), .ptr_lo(ptr_lo), .ptr_hi(ptr_hi),
        .chan_rstn(chan_rstn), .chan_en(chan_en),
        .smp_bits(smp_bits), .smp_valid(smp_valid)
    );

    // behavioural reference: integers for the count, shift history for the synchronizer delay
    int    m_cnt, m_fresh, m_level, m_locked;
    int    h1, h2, h3;
    logic [3:0] dh1, dh2;
    logic [7:0] exp_bits, exp_valid;
    string m_tag [8];

    function automatic int ptr_of(input int c);
        if (c < 4) return int'(ptr_lo[c*8 +: 8]);
        return int'(ptr_hi[(c-4)*8 +: 8]);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_fresh = 0; m_level = 0; m_locked = 0;
            h1 = 0; h2 = 0; h3 = 0; dh1 = '0; dh2 = '0;
            exp_bits = '0; exp_valid = '0;
            for (int c = 0; c < 8; c++) m_tag[c] = "R1";
        end else begin
            for (int c = 0; c < 8; c++) begin
                int want;
                want = ((c % 2) == 0) ? 1 : 0;
                if (!chan_rstn[c]) begin
                    exp_bits[c] = 1'b0; exp_valid[c] = 1'b0; m_tag[c] = "R5";
                end else if (!blk_en) begin
                    exp_valid[c] = 1'b0; m_tag[c] = "R7";
                end else if (!chan_en[c]) begin
                    exp_valid[c] = 1'b0; m_tag[c] = "R6";
                end else if (m_fresh != 0 && m_cnt == ptr_of(c) && m_level == want) begin
                    exp_bits[c] = dh2[c/2]; exp_valid[c] = 1'b1;
                    m_tag[c] = (c >= 4) ? "R4" : "R2";
                end else begin
                    exp_valid[c] = 1'b0; m_tag[c] = "R3";
                end
            end
            if (!blk_en) begin
                m_cnt = 0; m_fresh = 0; m_level = 0; m_locked = 0;
            end else if (h2 != h3) begin
                m_cnt = 0; m_fresh = 1; m_level = h2; m_locked = 1;
            end else if (m_locked != 0 && m_cnt < 255) begin
                m_cnt++; m_fresh = 1;
            end else begin
                m_fresh = 0;
            end
            h3 = h2; h2 = h1; h1 = int'(pdm_clk_in);
            dh2 = dh1; dh1 = pdm_data;
        end
    end

    int pulses [8];
    int dbl_pulses = 0;
    logic [7:0] prev_valid = '0;

    always @(negedge clk) begin
        if (!finished) begin
            for (int c = 0; c < 8; c++) begin
                checks++;
                if (smp_valid[c] !== exp_valid[c] || smp_bits[c] !== exp_bits[c]) begin
                    errors++;
                    $display("FAIL %s ch%0d: actual valid=%b bit=%b expected valid=%b bit=%b",
                             m_tag[c], c, smp_valid[c], smp_bits[c], exp_valid[c], exp_bits[c]);
                end
                if (smp_valid[c] === 1'b1) pulses[c]++;
                if (smp_valid[c] === 1'b1 && prev_valid[c] === 1'b1) dbl_pulses++;
            end
            prev_valid = smp_valid;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    int half_p = 20;
    bit pdm_run = 0;
    int ph_cnt = 0;

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pdm_run) begin
                ph_cnt++;
                if (ph_cnt >= half_p) begin
                    pdm_clk_in = ~pdm_clk_in;
                    ph_cnt = 0;
                end
            end
            pdm_data = 4'($urandom());
        end
    endtask

    task automatic clear_pulses();
        for (int c = 0; c < 8; c++) pulses[c] = 0;
    endtask

    initial begin
        clear_pulses();
        step(5);
        rst = 1'b0;
        step(1);
        check(smp_valid == 8'h00 && smp_bits == 8'h00, "R1", int'({smp_valid, smp_bits}), 0);

        // R2 R4: mixed pointers, all channels live
        ptr_lo = {8'd9, 8'd3, 8'd14, 8'd6};
        ptr_hi = {8'd1, 8'd11, 8'd0, 8'd17};
        chan_rstn = 8'hFF; chan_en = 8'hFF; blk_en = 1'b1;
        half_p = 20; pdm_run = 1;
        clear_pulses();
        step(400);
        check(pulses[0] > 5, "R2", pulses[0], 6);
        check(pulses[5] > 5, "R4", pulses[5], 6);

        // R5: upper channels held in reset
        chan_rstn = 8'h0F;
        step(3);
        clear_pulses();
        step(200);
        check(pulses[4] + pulses[5] + pulses[6] + pulses[7] == 0, "R5",
              pulses[4] + pulses[5] + pulses[6] + pulses[7], 0);
        check(smp_bits[7:4] == 4'h0, "R5", int'(smp_bits[7:4]), 0);

        // R6: enable mask clears some channels
        chan_rstn = 8'hFF; chan_en = 8'h5A;
        step(3);
        clear_pulses();
        step(200);
        check(pulses[0] == 0, "R6", pulses[0], 0);
        check(pulses[1] > 0, "R6", pulses[1], 1);

        // R3: short half period, pointers 14 and 17 never reached
        chan_en = 8'hFF; half_p = 7;
        step(20);
        clear_pulses();
        step(200);
        check(pulses[1] == 0, "R3", pulses[1], 0);
        check(pulses[4] == 0, "R3", pulses[4], 0);
        check(pulses[2] > 0, "R3", pulses[2], 1);

        // R7: global enable off, then on with a frozen PDM clock
        blk_en = 1'b0;
        step(3);
        clear_pulses();
        step(100);
        check(pulses[0] + pulses[1] + pulses[6] == 0, "R7", pulses[0] + pulses[1] + pulses[6], 0);
        pdm_run = 0;
        step(10);
        blk_en = 1'b1;
        clear_pulses();
        step(300);
        check(pulses[0] + pulses[3] + pulses[6] == 0, "R7", pulses[0] + pulses[3] + pulses[6], 0);

        // R8: pointer 255 on channel 0 with the clock stalled high
        ptr_lo[7:0] = 8'd255;
        if (pdm_clk_in == 1'b1) begin
            pdm_clk_in = 1'b0;
            step(30);
        end
        clear_pulses();
        pdm_clk_in = 1'b1;
        step(600);
        check(pulses[0] == 1, "R8", pulses[0], 1);
        check(pulses[2] == 1, "R8", pulses[2], 1);
        check(pulses[1] == 0, "R8", pulses[1], 0);

        // R9: long half periods, strobes stay single-cycle
        ptr_lo[7:0] = 8'd30;
        half_p = 40; pdm_run = 1;
        clear_pulses();
        step(800);
        check(pulses[0] > 5, "R9", pulses[0], 6);
        check(dbl_pulses == 0, "R9", dbl_pulses, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule